// File: doc/BRIEF.md
# Receive Cell Port for an ATM PHY (UTOPIA Slave)

This block sits on the PHY side of a receive path. Cells arrive already delineated, checked and filtered from an upstream cell processor on a line clock. Each one is delivered as a run of bus words: 53 bytes on an 8-bit bus, or 27 words on a 16-bit bus with a padding word after the header. The cells are stored in a receive buffer organised in whole-cell slots. The ATM layer reads them on its own, independent clock over a UTOPIA-style bus. That bus has an active-low read enable, a start-of-cell marker, an odd parity bit, and a combined cell-available/empty flag.

The line-side input is a valid/ready stream. `in_ready` is high whenever the write side is out of reset, so it never applies back-pressure. When the buffer has no free slot at the first word of a cell, that whole cell is discarded and a drop counter advances. Upstream is expected to present words only while `in_ready` is high, one word per line clock while `in_valid` is high.

On the read side a run-time setting picks between two handshakes. In the octet-style handshake the flag is a not-empty indication. In the cell-style handshake the flag means a whole unread cell is waiting. A second setting enables multi-PHY operation. Several ports then share the bus, each is polled and selected by a 5-bit address, and only the cell-style handshake is used.

Top module: `utopia_rx_slave`

## Requirements
- R1: While `rrst_n` is low the read outputs are `rx_data`=0, `rx_soc`=0, `rx_prty`=1, `rx_clav`=0 and `rx_clav_oe`=0. While `wrst_n` is low, `drop_count` is 0 and `in_ready` is 0.
- R2: On a rising `rclk` where `rx_enb_n` is low, a stored word exists, and (in multi-PHY mode) the port is selected, the next stored word appears on `rx_data` after that edge. Words leave in the order they were accepted.
- R3: On a rising `rclk` where `rx_enb_n` is high, `rx_data`, `rx_soc` and `rx_prty` keep their values. The same holds when enable is low but nothing is stored.
- R4: `rx_soc` is 1 with the first word of each cell and 0 with every other word.
- R5: `rx_prty` is odd parity over `rx_data`: the total count of ones in `{rx_data, rx_prty}` is odd. It updates together with the data.
- R6: In single-PHY cell-style mode (`cfg_octet`=0, `cfg_multi`=0), `rx_clav` is registered once per `rclk`. It is 1 when at least one complete cell beyond the cell currently being read is stored. `rx_clav_oe` is 1.
- R7: In single-PHY octet-style mode (`cfg_octet`=1, `cfg_multi`=0), `rx_clav` is 1 exactly when at least one word is stored (0 means empty). This includes the remainder of a partly read cell.
- R8: In multi-PHY mode, `rx_clav_oe` and `rx_clav` follow one `rclk` after the address bus. `rx_clav_oe` is 1 only after `rx_addr` equalled `phy_id`. `rx_clav` is then the cell-style flag, and otherwise it is 0.
- R9: With `cfg_multi`=1 the cell-style flag is used even when `cfg_octet`=1.
- R10: In multi-PHY mode, the port is selected at an `rclk` edge with `rx_enb_n` high and `rx_addr`=`phy_id`. It is deselected at such an edge with any other address. Words move only while it is selected.
- R11: A cell whose first word arrives while all `CELLS` slots are occupied is discarded in full, and `drop_count` increases by one. Cells that were accepted are never overwritten.
- R12: `in_ready` is 1 from the first `wclk` edge after `wrst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Line-side write clock |
| wrst_n | input | 1 | Asynchronous active-low reset, write side |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input accepted (high whenever out of reset) |
| in_data | input | BUS_W | Input cell word |
| drop_count | output | CNT_W | Count of discarded cells (wraps) |
| rclk | input | 1 | ATM-layer read clock |
| rrst_n | input | 1 | Asynchronous active-low reset, read side |
| cfg_octet | input | 1 | 1 selects the octet-style handshake (single-PHY only) |
| cfg_multi | input | 1 | 1 selects multi-PHY polled operation |
| phy_id | input | 5 | This port's bus address |
| rx_addr | input | 5 | Address bus from the ATM layer |
| rx_enb_n | input | 1 | Active-low read enable |
| rx_data | output | BUS_W | Cell word out |
| rx_soc | output | 1 | Start of cell |
| rx_prty | output | 1 | Odd parity of rx_data |
| rx_clav | output | 1 | Cell available / not-empty flag |
| rx_clav_oe | output | 1 | Flag drive enable |

## Verification
A word enabled at rising `rclk` edge n is on `rx_data`, `rx_soc` and `rx_prty` after edge n. `rx_clav`, `rx_clav_oe` and the selection state are also settled one edge after the inputs they depend on. The bench's behavioural model advances on the same edge and is compared on the following falling edge. A cell committed on the line side reaches the read-side flags only after a gray-code hand-off of a few clocks. Flag comparisons are therefore suspended while cells are being written, and resume twelve `rclk` cycles after the last write, when both sides have settled. `drop_count` is compared only at those settled points.

// File: rtl/urx_pkg.sv
package urx_pkg;
  // Bus words per cell for a given data bus width.
  function automatic int unsigned words_per_cell(int unsigned bus_w);
    return (bus_w == 16) ? 27 : 53;
  endfunction
endpackage

// File: rtl/urx_gray_sync.sv
module urx_gray_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] meta_q, safe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      safe_q <= '0;
    end else begin
      meta_q <= gray_in;
      safe_q <= meta_q;
    end
  end

  always_comb begin
    bin_out = safe_q;
    for (int i = W - 2; i >= 0; i--) bin_out[i] = bin_out[i+1] ^ safe_q[i];
  end
endmodule

// File: rtl/urx_wr_side.sv
module urx_wr_side #(
  parameter int BUS_W = 8,
  parameter int WPC   = 53,
  parameter int CW    = 2,
  parameter int MA    = 8,
  parameter int CNT_W = 16
) (
  input  logic             wclk,
  input  logic             wrst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [BUS_W-1:0] in_data,
  input  logic [CW:0]      rcell_bin,
  output logic             mem_we,
  output logic [MA-1:0]    mem_waddr,
  output logic [BUS_W-1:0] mem_wdata,
  output logic [CW:0]      wcell_gray,
  output logic [CNT_W-1:0] drop_count
);
  localparam int IW = $clog2(WPC);
  localparam logic [MA-1:0] WPC_M = MA'(WPC);

  logic [IW-1:0] widx;
  logic [CW:0]   wcell, used;
  logic          dropping, first, last, full, keep;

  assign used  = wcell - rcell_bin;
  assign full  = used[CW];
  assign first = (widx == '0);
  assign last  = (widx == IW'(WPC - 1));
  assign keep  = first ? !full : !dropping;

  assign mem_we    = in_valid && keep;
  assign mem_waddr = MA'(wcell[CW-1:0]) * WPC_M + MA'(widx);
  assign mem_wdata = in_data;

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      widx       <= '0;
      wcell      <= '0;
      wcell_gray <= '0;
      dropping   <= 1'b0;
      drop_count <= '0;
      in_ready   <= 1'b0;
    end else begin
      in_ready   <= 1'b1;
      wcell_gray <= wcell ^ (wcell >> 1);
      if (in_valid) begin
        widx <= last ? '0 : widx + 1'b1;
        if (first) begin
          dropping <= full;
          if (full) drop_count <= drop_count + 1'b1;
        end
        if (last && keep) wcell <= wcell + 1'b1;
      end
    end
  end

  AST_DROP_COUNTED: assert property (@(posedge wclk) disable iff (!wrst_n)
    (in_valid && first && full) |=> (drop_count != $past(drop_count))); // R11
  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!wrst_n)
    used <= (CW+1)'(2**CW)); // R11
endmodule

// File: rtl/urx_rd_side.sv
module urx_rd_side #(
  parameter int BUS_W = 8,
  parameter int WPC   = 53,
  parameter int CW    = 2,
  parameter int MA    = 8
) (
  input  logic             rclk,
  input  logic             rrst_n,
  input  logic             cfg_octet,
  input  logic             cfg_multi,
  input  logic [4:0]       phy_id,
  input  logic [4:0]       rx_addr,
  input  logic             rx_enb_n,
  input  logic [CW:0]      wcell_bin,
  output logic [MA-1:0]    mem_raddr,
  input  logic [BUS_W-1:0] mem_rdata,
  output logic [BUS_W-1:0] rx_data,
  output logic             rx_soc,
  output logic             rx_prty,
  output logic             rx_clav,
  output logic             rx_clav_oe,
  output logic [CW:0]      rcell_gray
);
  localparam int IW = $clog2(WPC);
  localparam logic [MA-1:0] WPC_M = MA'(WPC);

  logic [IW-1:0] ridx;
  logic [CW:0]   rcell, avail;
  logic          sel, hit, has_word, cell_clav, octet_eff, xfer, last;

  assign avail     = wcell_bin - rcell;
  assign has_word  = (avail != '0);
  assign cell_clav = avail > {{CW{1'b0}}, (ridx != '0)};
  assign octet_eff = cfg_octet && !cfg_multi;
  assign hit       = (rx_addr == phy_id);
  assign xfer      = !rx_enb_n && has_word && (!cfg_multi || sel);
  assign last      = (ridx == IW'(WPC - 1));
  assign mem_raddr = MA'(rcell[CW-1:0]) * WPC_M + MA'(ridx);

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rx_data    <= '0;
      rx_soc     <= 1'b0;
      rx_prty    <= 1'b1;
      rx_clav    <= 1'b0;
      rx_clav_oe <= 1'b0;
      sel        <= 1'b0;
      ridx       <= '0;
      rcell      <= '0;
      rcell_gray <= '0;
    end else begin
      rcell_gray <= rcell ^ (rcell >> 1);
      if (cfg_multi) begin
        rx_clav    <= hit && cell_clav;
        rx_clav_oe <= hit;
        if (rx_enb_n) sel <= hit;
      end else begin
        rx_clav    <= octet_eff ? has_word : cell_clav;
        rx_clav_oe <= 1'b1;
        sel        <= 1'b0;
      end
      if (xfer) begin
        rx_data <= mem_rdata;
        rx_soc  <= (ridx == '0);
        rx_prty <= ~^mem_rdata;
        ridx    <= last ? '0 : ridx + 1'b1;
        if (last) rcell <= rcell + 1'b1;
      end
    end
  end

  AST_HOLD_DISABLED: assert property (@(posedge rclk) disable iff (!rrst_n)
    rx_enb_n |=> ($stable(rx_data) && $stable(rx_soc) && $stable(rx_prty))); // R3
  AST_PARITY_ODD: assert property (@(posedge rclk) disable iff (!rrst_n)
    (($countones({rx_data, rx_prty}) % 2) == 1)); // R5
  AST_UNSELECTED_HOLD: assert property (@(posedge rclk) disable iff (!rrst_n)
    (cfg_multi && !sel) |=> $stable(rx_data)); // R10
  AST_QUIET_OFF_ADDR: assert property (@(posedge rclk) disable iff (!rrst_n)
    (cfg_multi && !hit) |=> (!rx_clav_oe && !rx_clav)); // R8
  AST_CELLS_BOUNDED: assert property (@(posedge rclk) disable iff (!rrst_n)
    avail <= (CW+1)'(2**CW)); // R11
endmodule

// File: rtl/utopia_rx_slave.sv
module utopia_rx_slave #(
  parameter int BUS_W = 8,
  parameter int CELLS = 4,
  parameter int CNT_W = 16
) (
  input  logic             wclk,
  input  logic             wrst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [BUS_W-1:0] in_data,
  output logic [CNT_W-1:0] drop_count,
  input  logic             rclk,
  input  logic             rrst_n,
  input  logic             cfg_octet,
  input  logic             cfg_multi,
  input  logic [4:0]       phy_id,
  input  logic [4:0]       rx_addr,
  input  logic             rx_enb_n,
  output logic [BUS_W-1:0] rx_data,
  output logic             rx_soc,
  output logic             rx_prty,
  output logic             rx_clav,
  output logic             rx_clav_oe
);
  localparam int WPC   = urx_pkg::words_per_cell(BUS_W);
  localparam int CW    = (CELLS < 2) ? 1 : $clog2(CELLS);
  localparam int DEPTH = (2**CW) * WPC;
  localparam int MA    = $clog2(DEPTH);

  logic [BUS_W-1:0] mem [DEPTH];
  logic             mem_we;
  logic [MA-1:0]    mem_waddr, mem_raddr;
  logic [BUS_W-1:0] mem_wdata, mem_rdata;
  logic [CW:0]      wcell_gray, rcell_gray, wcell_bin, rcell_bin;

  always_ff @(posedge wclk) begin
    if (mem_we) mem[mem_waddr] <= mem_wdata;
  end
  assign mem_rdata = mem[mem_raddr];

  urx_wr_side #(.BUS_W(BUS_W), .WPC(WPC), .CW(CW), .MA(MA), .CNT_W(CNT_W)) u_wr (
    .wclk(wclk), .wrst_n(wrst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .rcell_bin(rcell_bin), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .wcell_gray(wcell_gray),
    .drop_count(drop_count)
  );

  urx_gray_sync #(.W(CW + 1)) u_w2r (
    .clk(rclk), .rst_n(rrst_n), .gray_in(wcell_gray), .bin_out(wcell_bin)
  );

  urx_gray_sync #(.W(CW + 1)) u_r2w (
    .clk(wclk), .rst_n(wrst_n), .gray_in(rcell_gray), .bin_out(rcell_bin)
  );

  urx_rd_side #(.BUS_W(BUS_W), .WPC(WPC), .CW(CW), .MA(MA)) u_rd (
    .rclk(rclk), .rrst_n(rrst_n), .cfg_octet(cfg_octet), .cfg_multi(cfg_multi),
    .phy_id(phy_id), .rx_addr(rx_addr), .rx_enb_n(rx_enb_n),
    .wcell_bin(wcell_bin), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .rx_data(rx_data), .rx_soc(rx_soc), .rx_prty(rx_prty),
    .rx_clav(rx_clav), .rx_clav_oe(rx_clav_oe), .rcell_gray(rcell_gray)
  );
endmodule

// File: tb/utopia_rx_slave_test.sv
module utopia_rx_slave_test;
  localparam int WPC = 53;
  localparam int NC  = 4;

  logic wclk = 0, rclk = 0, rst_n = 0;
  logic in_valid = 0, cfg_octet = 0, cfg_multi = 0, rx_enb_n = 1;
  logic [7:0] in_data = 0;
  logic [4:0] phy_id = 5'd5, rx_addr = 5'd31;
  logic in_ready, rx_soc, rx_prty, rx_clav, rx_clav_oe;
  logic [7:0] rx_data;
  logic [15:0] drop_count;

  int checks = 0, errors = 0, exp_drops = 0;
  bit clav_chk = 0;

  // behavioural reference state
  bit [7:0] wq[$];
  int m_cells = 0, m_idx = 0;
  bit m_sel = 0;
  logic [7:0] e_data = 0;
  logic e_soc = 0, e_prty = 1, e_clav = 0, e_oe = 0;
  string d_tag = "R2", c_tag = "R6";

  utopia_rx_slave uut (
    .wclk(wclk), .wrst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .drop_count(drop_count), .rclk(rclk), .rrst_n(rst_n),
    .cfg_octet(cfg_octet), .cfg_multi(cfg_multi), .phy_id(phy_id),
    .rx_addr(rx_addr), .rx_enb_n(rx_enb_n), .rx_data(rx_data), .rx_soc(rx_soc),
    .rx_prty(rx_prty), .rx_clav(rx_clav), .rx_clav_oe(rx_clav_oe)
  );

  always #10 rclk = ~rclk;
  initial begin #2; forever #7 wclk = ~wclk; end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge rclk) begin
    if (rst_n) begin
      bit cc, hit, xfer;
      cc   = m_cells > ((m_idx != 0) ? 1 : 0);
      hit  = (rx_addr == phy_id);
      xfer = !rx_enb_n && (m_cells != 0) && (!cfg_multi || m_sel);
      d_tag = rx_enb_n ? "R3" : (cfg_multi ? "R10" : "R2");
      c_tag = cfg_multi ? (cfg_octet ? "R9" : "R8") : (cfg_octet ? "R7" : "R6");
      if (cfg_multi) begin e_clav = hit && cc; e_oe = hit; end
      else begin e_clav = cfg_octet ? (m_cells != 0) : cc; e_oe = 1; end
      if (cfg_multi && rx_enb_n) m_sel = hit;
      else if (!cfg_multi) m_sel = 0;
      if (xfer) begin
        e_data = wq.pop_front();
        e_soc  = (m_idx == 0);
        e_prty = ~^e_data;
        m_idx++;
        if (m_idx == WPC) begin m_idx = 0; m_cells--; end
      end
    end
  end

  always @(negedge rclk) begin
    if (rst_n) begin
      check(rx_data, e_data, d_tag);
      check(rx_soc, e_soc, "R4");
      check(rx_prty, e_prty, "R5");
      if (clav_chk) begin
        check(rx_clav, e_clav, c_tag);
        check(rx_clav_oe, e_oe, c_tag);
      end
    end
  end

  task automatic write_cell(input logic [7:0] base);
    bit keep;
    keep = (m_cells < NC);
    if (!keep) exp_drops++;
    for (int i = 0; i < WPC; i++) begin
      @(negedge wclk);
      in_valid = 1;
      in_data  = base + 8'(i);
    end
    @(negedge wclk);
    in_valid = 0;
    if (keep) begin
      for (int i = 0; i < WPC; i++) wq.push_back(base + 8'(i));
      m_cells++;
    end
  endtask

  task automatic settle();
    repeat (12) @(negedge rclk);
    clav_chk = 1;
    check(drop_count, exp_drops, "R11");
  endtask

  task automatic cyc(input logic enb, input logic [4:0] addr, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge rclk);
      rx_enb_n = enb;
      rx_addr  = addr;
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge rclk);
    // R1 reset values
    check(rx_data, 0, "R1");
    check(rx_soc, 0, "R1");
    check(rx_prty, 1, "R1");
    check(rx_clav, 0, "R1");
    check(rx_clav_oe, 0, "R1");
    check(drop_count, 0, "R1");
    check(in_ready, 0, "R1");
    rst_n = 1;
    repeat (3) @(negedge rclk);
    check(in_ready, 1, "R12");
    clav_chk = 1;

    // single-PHY cell-style
    clav_chk = 0;
    write_cell(8'h10);
    write_cell(8'h80);
    settle();
    cyc(0, 31, 30);
    cyc(1, 31, 4);    // R3 hold mid-cell
    cyc(0, 31, 90);   // drain and hold on empty
    cyc(1, 31, 3);

    // single-PHY octet-style
    cfg_octet = 1;
    clav_chk = 0;
    write_cell(8'h33);
    settle();
    cyc(0, 31, 10);
    cyc(1, 31, 3);    // R7 flag stays up mid-cell
    cyc(0, 31, 50);
    cyc(1, 31, 3);

    // overflow: fifth cell dropped
    cfg_octet = 0;
    clav_chk = 0;
    for (int c = 0; c < 5; c++) write_cell(8'(c * 16 + 1));
    settle();
    cyc(0, 31, 4 * WPC + 5);
    cyc(1, 31, 3);

    // multi-PHY polling
    cfg_multi = 1;
    clav_chk = 0;
    write_cell(8'hA0);
    write_cell(8'h05);
    settle();
    cyc(1, 7, 3);     // R8 other address: quiet
    cyc(1, 5, 3);     // R8 own address: flag driven, R10 select
    cyc(0, 5, 20);
    cyc(1, 7, 2);     // deselect
    cyc(0, 7, 5);     // R10 no transfer
    cfg_octet = 1;    // R9 ignored in multi-PHY
    cyc(1, 5, 2);
    cyc(0, 5, 40);
    cyc(1, 5, 4);     // flag low: partial cell only
    cyc(0, 5, 60);
    cyc(1, 31, 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule